// File: doc/BRIEF.md
# ADC Readout Handshake Controller

This block sits between a two-channel detector ADC and a downstream sample sink. A static enable output turns the converter on for a run and off at its end. Each time the converter raises its ready line, the block captures the two 13-bit channel values exactly once and packs them into one 32-bit word. It offers that word to the sink on a valid/ready handshake. Only after the sink has accepted the word does it pulse an acknowledge line back to the converter, so the converter can take the next detector event.

The block also measures dead time. One counter runs on every clock cycle in which the converter's busy (composite dead-time) input is high. A second counter runs on every cycle in which the enable output is high, and the host derives live time from the two. Both counters saturate rather than wrap, and a clear input zeroes both. The ready and busy inputs are asynchronous, and each passes through a two-flop synchronizer.

Top module: `adc_readout_ctrl`

## Requirements
- R1: `adc_enable` is low after reset and takes the value of `run_en` one clock later.
- R2: A capture happens only on a low-to-high transition of the synchronized ready line while `adc_enable` is high. Ready that stays high yields no further captures, and ready that rises while `adc_enable` is low yields none.
- R3: The output word carries `ch_a` in bits 12:0 and `ch_b` in bits 28:16. Bits 15:13 and 31:29 are zero.
- R4: `smp_valid` goes high on the third rising clock edge after `adc_ready` rises. It stays high with `smp_word` unchanged until the cycle in which `smp_ready` is high.
- R5: `adc_ack` rises on the clock edge after the acceptance and stays high for `ack_width` cycles. A width of 0 gives one cycle. `adc_ack` and `smp_valid` are never high together.
- R6: While the sink holds `smp_ready` low, no acknowledge is sent and the pending word is kept.
- R7: `dt_count` increases by one for each cycle in which `adc_busy` is high, with a two-cycle synchronizer lag. It does not change while `adc_busy` is low.
- R8: `run_count` increases by one for each cycle in which `adc_enable` is high, and does not change while it is low.
- R9: Both counters stop at their all-ones value instead of wrapping.
- R10: `clr_counts` zeroes both counters on the next edge, and it takes priority over counting.
- R11: After reset `smp_valid`, `adc_ack` and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Host request to run acquisition |
| ack_width | input | 8 | Acknowledge pulse length in cycles (0 acts as 1) |
| clr_counts | input | 1 | Clear both counters |
| adc_ready | input | 1 | Asynchronous data-ready from the ADC |
| adc_busy | input | 1 | Asynchronous composite dead-time from the ADC |
| ch_a | input | 13 | First channel value, stable while ready is high |
| ch_b | input | 13 | Second channel value, stable while ready is high |
| adc_enable | output | 1 | Static enable to the ADC |
| adc_ack | output | 1 | Acknowledge/reset pulse to the ADC |
| smp_valid | output | 1 | Captured word available |
| smp_ready | input | 1 | Sink accepts the word |
| smp_word | output | 32 | Packed sample word |
| dt_count | output | 32 | Dead-time cycle count |
| run_count | output | 32 | Enabled-time cycle count |

## Verification
The assertions take for granted that the ADC keeps both channel values stable from the rise of ready until the acknowledge. They also take for granted that the ADC does not raise ready again before it has seen the acknowledge. They do not check what happens when the ready line bounces. The stimulus sets the channel values in the same cycle as ready, holds them until the acknowledge has ended, and drops ready only afterwards. Every ready and busy change is driven on the falling clock edge, so the synchronizer lag is fixed at two cycles.

// File: rtl/adc_rd_pkg.sv
// Shared types for the ADC readout controller.
package adc_rd_pkg;
    // Capture/acknowledge sequence states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a ready edge
        ST_HOLD = 2'd1,   // word offered, waiting for the sink
        ST_ACK  = 2'd2    // acknowledge pulse to the ADC
    } cap_state_t;
endpackage

// File: rtl/adc_rd_sync.sv
// Two-flop synchronizer, one lane per bit.
// Assumes: each input bit is an independent level; no bus coherence is needed.
module adc_rd_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        logic meta_q;
        logic stab_q;
        // Two-stage resampling of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_async[i];
                stab_q <= meta_q;
            end
        end
        assign d_sync[i] = stab_q;
    end
endmodule

// File: rtl/adc_rd_sat_cnt.sv
// Saturating up-counter with a clear input that takes priority.
// Assumes: the host reads the counter value directly; no snapshot is taken.
module adc_rd_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Clear first, then count up until the all-ones value is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/adc_rd_capture.sv
// Edge-triggered capture with sink handshake and acknowledge pulse.
// Assumes: the channel values are stable while ready is high, and the ADC
// raises ready again only after the acknowledge.
module adc_rd_capture
    import adc_rd_pkg::*;
#(
    parameter int CH_W   = 13,
    parameter int WORD_W = 32,
    parameter int AW_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rdy_sync,
    input  logic [CH_W-1:0]   ch_a,
    input  logic [CH_W-1:0]   ch_b,
    input  logic [AW_W-1:0]   ack_width,
    output logic              smp_valid,
    input  logic              smp_ready,
    output logic [WORD_W-1:0] smp_word,
    output logic              ack
);
    localparam int LANE = WORD_W / 2;

    cap_state_t      state_q;
    logic            rdy_prev_q;
    logic            rise;
    logic [AW_W-1:0] ack_left_q;
    logic [WORD_W-1:0] packed_w;

    // Remember the previous ready level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_prev_q <= 1'b0;
        else        rdy_prev_q <= rdy_sync;
    end

    assign rise = rdy_sync && !rdy_prev_q;

    // Place each channel at the bottom of its half-word; zero the rest.
    always_comb begin
        packed_w = '0;
        packed_w[CH_W-1:0]         = ch_a;
        packed_w[LANE+CH_W-1:LANE] = ch_b;
    end

    // Capture, wait for the sink, then time the acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            smp_word   <= '0;
            ack_left_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (rise && enable) begin
                    smp_word <= packed_w;
                    state_q  <= ST_HOLD;
                end
                ST_HOLD: if (smp_ready) begin
                    ack_left_q <= (ack_width == '0) ? '0 : ack_width - 1'b1;
                    state_q    <= ST_ACK;
                end
                ST_ACK: begin
                    if (ack_left_q == '0) state_q <= ST_IDLE;
                    else                  ack_left_q <= ack_left_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign smp_valid = (state_q == ST_HOLD);
    assign ack       = (state_q == ST_ACK);
endmodule

// File: rtl/adc_readout_ctrl.sv
// ADC readout controller top: enable line, edge capture with per-sample
// acknowledge, and saturating dead-time and run-time counters.
// Assumes: adc_ready and adc_busy are asynchronous; ch_a/ch_b are stable
// whenever adc_ready is high.
module adc_readout_ctrl #(
    parameter int CH_W   = 13,
    parameter int WORD_W = 32,
    parameter int AW_W   = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [AW_W-1:0]   ack_width,
    input  logic              clr_counts,
    input  logic              adc_ready,
    input  logic              adc_busy,
    input  logic [CH_W-1:0]   ch_a,
    input  logic [CH_W-1:0]   ch_b,
    output logic              adc_enable,
    output logic              adc_ack,
    output logic              smp_valid,
    input  logic              smp_ready,
    output logic [WORD_W-1:0] smp_word,
    output logic [CNT_W-1:0]  dt_count,
    output logic [CNT_W-1:0]  run_count
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] sync_out;

    // Static enable register toward the ADC.
    always_ff @(posedge clk) begin
        if (!rst_n) adc_enable <= 1'b0;
        else        adc_enable <= run_en;
    end

    adc_rd_sync #(.W(NSYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({adc_busy, adc_ready}),
        .d_sync  (sync_out)
    );

    adc_rd_capture #(.CH_W(CH_W), .WORD_W(WORD_W), .AW_W(AW_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (adc_enable),
        .rdy_sync  (sync_out[0]),
        .ch_a      (ch_a),
        .ch_b      (ch_b),
        .ack_width (ack_width),
        .smp_valid (smp_valid),
        .smp_ready (smp_ready),
        .smp_word  (smp_word),
        .ack       (adc_ack)
    );

    adc_rd_sat_cnt #(.W(CNT_W)) u_dead (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_counts),
        .inc   (sync_out[1]),
        .count (dt_count)
    );

    adc_rd_sat_cnt #(.W(CNT_W)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_counts),
        .inc   (adc_enable),
        .count (run_count)
    );
endmodule

// File: rtl/adc_readout_ctrl_chk.sv
// Protocol checker for adc_readout_ctrl, observing its ports only.
module adc_readout_ctrl_chk #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_enable,
    input logic              adc_ack,
    input logic              smp_valid,
    input logic              smp_ready,
    input logic [WORD_W-1:0] smp_word,
    input logic              clr_counts,
    input logic [CNT_W-1:0]  dt_count,
    input logic [CNT_W-1:0]  run_count
);
    AST_CAPTURE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_valid) |-> $past(adc_enable));                            // R2
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_word)));    // R4
    AST_ACK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_ack) |-> $past(smp_valid && smp_ready));                  // R5
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_ack && smp_valid));                                           // R5
    AST_RUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_enable && !clr_counts) |=> $stable(run_count));               // R8
    AST_DT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_counts |=> (dt_count >= $past(dt_count)));                     // R9
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_counts |=> (dt_count == '0 && run_count == '0));                // R10
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_enable (adc_enable),
    .adc_ack    (adc_ack),
    .smp_valid  (smp_valid),
    .smp_ready  (smp_ready),
    .smp_word   (smp_word),
    .clr_counts (clr_counts),
    .dt_count   (dt_count),
    .run_count  (run_count)
);

// File: tb/adc_readout_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module adc_readout_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_en = 1'b0;
    logic [7:0]       ack_width = 8'd1;
    logic             clr_counts = 1'b0;
    logic             adc_ready = 1'b0;
    logic             adc_busy = 1'b0;
    logic [12:0]      ch_a = '0;
    logic [12:0]      ch_b = '0;
    logic             adc_enable, adc_ack, smp_valid;
    logic             smp_ready = 1'b1;
    logic [31:0]      smp_word;
    logic [CNT_W-1:0] dt_count, run_count;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_readout_ctrl #(.CNT_W(CNT_W)) u_adc_readout_ctrl (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ack_width(ack_width),
        .clr_counts(clr_counts), .adc_ready(adc_ready), .adc_busy(adc_busy),
        .ch_a(ch_a), .ch_b(ch_b), .adc_enable(adc_enable), .adc_ack(adc_ack),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_word(smp_word),
        .dt_count(dt_count), .run_count(run_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_counts();
        @(negedge clk); clr_counts = 1'b1;
        @(negedge clk); clr_counts = 1'b0;
    endtask

    // One ADC event: returns latency, captured word and acknowledge width.
    task automatic do_event(input logic [12:0] a, input logic [12:0] b, input bit drop,
                            output int lat, output logic [31:0] word, output int aw);
        int g;
        @(negedge clk); ch_a = a; ch_b = b; adc_ready = 1'b1;
        lat = 0;
        while (!smp_valid && lat < 20) begin @(negedge clk); lat++; end
        word = smp_word;
        g = 0;
        while (!adc_ack && g < 50) begin @(negedge clk); g++; end
        aw = 0;
        while (adc_ack && aw < 300) begin @(negedge clk); aw++; end
        if (drop) adc_ready = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 valid", {31'd0, smp_valid}, 32'd0);
        check("R11 ack", {31'd0, adc_ack}, 32'd0);
        check("R11 dt", {22'd0, dt_count}, 32'd0);
        check("R11 run", {22'd0, run_count}, 32'd0);
        check("R1 enable at reset", {31'd0, adc_enable}, 32'd0);
    endtask

    task automatic t_enable();
        @(negedge clk); run_en = 1'b1;
        @(negedge clk);
        check("R1 enable follows", {31'd0, adc_enable}, 32'd1);
    endtask

    task automatic t_capture();
        int lat, aw; logic [31:0] w;
        ack_width = 8'd4;
        do_event(13'h1ABC, 13'h0123, 1'b1, lat, w, aw);
        check("R4 latency", lat, 32'd3);
        check("R3 packing", w, 32'h0123_1ABC);
        check("R5 ack width 4", aw, 32'd4);
        idle(3);
        ack_width = 8'd0;
        do_event(13'h1FFF, 13'h1FFF, 1'b1, lat, w, aw);
        check("R3 packing all ones", w, 32'h1FFF_1FFF);
        check("R5 width 0 gives 1", aw, 32'd1);
        idle(3);
    endtask

    task automatic t_single_shot();
        int lat, aw, extra; logic [31:0] w;
        ack_width = 8'd2;
        do_event(13'h0005, 13'h000A, 1'b0, lat, w, aw);
        extra = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (smp_valid) extra++;
        end
        check("R2 one capture per edge", extra, 32'd0);
        adc_ready = 1'b0;
        idle(3);
        do_event(13'h0777, 13'h1000, 1'b1, lat, w, aw);
        check("R2 next edge captured", w, 32'h1000_0777);
        idle(3);
    endtask

    task automatic t_backpressure();
        int lat, aw, acks; logic [31:0] w;
        smp_ready = 1'b0; ack_width = 8'd3;
        @(negedge clk); ch_a = 13'h0AAA; ch_b = 13'h1555; adc_ready = 1'b1;
        acks = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (adc_ack) acks++;
        end
        check("R6 no ack while stalled", acks, 32'd0);
        check("R6 valid held", {31'd0, smp_valid}, 32'd1);
        check("R4 word held", smp_word, 32'h1555_0AAA);
        smp_ready = 1'b1;
        @(negedge clk);
        check("R5 ack after accept", {31'd0, adc_ack}, 32'd1);
        check("R5 valid dropped", {31'd0, smp_valid}, 32'd0);
        aw = 0;
        while (adc_ack && aw < 50) begin @(negedge clk); aw++; end
        check("R5 ack width 3", aw, 32'd3);
        adc_ready = 1'b0;
        idle(3);
    endtask

    task automatic t_disabled();
        int seen;
        @(negedge clk); run_en = 1'b0;
        idle(2);
        adc_ready = 1'b1;
        seen = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (smp_valid || adc_ack) seen++;
        end
        check("R2 ignored while disabled", seen, 32'd0);
        adc_ready = 1'b0;
        idle(3);
    endtask

    task automatic t_runtime();
        run_en = 1'b0;
        idle(3);
        clear_counts();
        run_en = 1'b1;
        idle(50);
        run_en = 1'b0;
        idle(4);
        check("R8 run count 50", {22'd0, run_count}, 32'd50);
        idle(5);
        check("R8 run count stops", {22'd0, run_count}, 32'd50);
    endtask

    task automatic t_deadtime();
        clear_counts();
        adc_busy = 1'b1;
        idle(37);
        adc_busy = 1'b0;
        idle(4);
        check("R7 dead count 37", {22'd0, dt_count}, 32'd37);
        idle(10);
        check("R7 dead count holds", {22'd0, dt_count}, 32'd37);
    endtask

    task automatic t_saturate();
        clear_counts();
        adc_busy = 1'b1;
        idle(1100);
        check("R9 saturate", {22'd0, dt_count}, 32'd1023);
        clear_counts();
        check("R10 clear beats count", {22'd0, dt_count}, 32'd0);
        adc_busy = 1'b0;
        idle(4);
        clear_counts();
        check("R10 run cleared", {22'd0, run_count}, 32'd0);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            vecs++; errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_capture();
        t_single_shot();
        t_backpressure();
        t_disabled();
        t_runtime();
        t_deadtime();
        t_saturate();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule